// File: doc/BRIEF.md
# Trap Entry and Interrupt Level Controller

This block sits beside the integer pipeline and decides when the processor abandons its normal instruction stream. It holds the trap-related processor state: the trap enable bit, the supervisor bit and its saved copy, the 4-bit interrupt mask level, the current window pointer, the trap base register with its trap-type field, and the program counter pair. Every cycle it weighs a synchronous trap request from the pipeline against fifteen external interrupt lines. The lines are filtered through the mask level, and the block carries out the hardware part of trap entry in a single clock.

On entry the block points fetch at the handler vector. The vector is the trap base with the trap type inserted at bits 11:4. The block also sends the interrupted program counter pair out on a valid/ready stream. The register file writes that pair into two locals of the newly selected window. While a saved pair waits for `sv_ready`, the block accepts no further trap. A synchronous trap is back-pressured through `strap_ready`, and interrupts stay pending. A synchronous trap that arrives while traps are disabled does not enter a handler. It drops the block into a sticky error state that stops fetch until a reset trap.

The pipeline reports each completed instruction with `retire` and supplies the address that follows the new `npc`. Software state updates arrive on the write ports. Those updates and retirement both lose to a trap entry taken in the same cycle.

Top module: `trap_entry_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge the block initializes to: et=0, s=1, ps=0, pil=0, cwp=0, tbr=0, pc=0, npc=4, err_mode=0, sv_valid=0, redirect=0.
- R2: A clock edge with `rst_trap` high (and `rst_n` high) sets et=0, s=1, pc=0 and npc=4, clears err_mode and sv_valid, and leaves ps, pil, cwp and tbr unchanged. It takes priority over every other input.
- R3: Interrupt line `irq_req[L]` (L = 1..15) is eligible when et=1 and either L > pil or L = 15. The highest eligible level is taken. A request at or below pil (other than 15) changes no state.
- R4: While et=0, interrupt requests change no state and cause no redirect.
- R5: On any trap entry: et becomes 0, ps receives the old s, s becomes 1, cwp becomes (cwp − 1) mod NWIN, and pil is unchanged.
- R6: On trap entry, tbr bits 11:4 receive the trap type: `strap_tt` for a synchronous trap, 0x10+L for interrupt level L. pc becomes the new tbr and npc becomes pc+4. `redirect` is high for exactly the cycle after the entry edge.
- R7: The saved pair is the old (pc, npc) for a synchronous trap. For an interrupt it is (npc, retire_npc) when `retire` is high in the entry cycle, and (pc, npc) otherwise. `sv_win` carries the new cwp.
- R8: `sv_valid` rises on entry and holds with stable `sv_pc`/`sv_npc`/`sv_win` until a cycle with `sv_ready` high. While it is held with `sv_ready` low, no trap is accepted and `strap_ready` is low while et=1.
- R9: A synchronous trap and an interrupt presented in the same cycle: the synchronous trap is taken.
- R10: `strap_valid` with et=0 sets err_mode. err_mode stays set, holds `fetch_en` low and freezes all state against retire, writes and traps until a reset trap.
- R11: In a cycle without trap, error or reset, `psr_we` loads et, s, ps, pil and cwp; `tbr_we` loads tbr bits 31:12; `retire` moves npc into pc and `retire_npc` into npc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rst_trap | input | 1 | Reset trap request |
| irq_req | input | 15 | Interrupt lines, bit L is level L (15:1) |
| strap_valid | input | 1 | Synchronous trap request |
| strap_ready | output | 1 | Synchronous trap consumed this cycle |
| strap_tt | input | 8 | Trap type of the synchronous trap |
| retire | input | 1 | Current instruction completes this cycle |
| retire_npc | input | 32 | Address following the new npc |
| psr_we | input | 1 | Load processor state fields |
| psr_et | input | 1 | Trap enable to load |
| psr_s | input | 1 | Supervisor bit to load |
| psr_ps | input | 1 | Saved supervisor bit to load |
| psr_pil | input | 4 | Interrupt mask level to load |
| psr_cwp | input | 3 | Window pointer to load |
| tbr_we | input | 1 | Load trap base |
| tbr_base | input | 20 | Trap base, tbr bits 31:12 |
| et | output | 1 | Trap enable |
| s | output | 1 | Supervisor bit |
| ps | output | 1 | Saved supervisor bit |
| pil | output | 4 | Interrupt mask level |
| cwp | output | 3 | Current window pointer |
| tbr | output | 32 | Trap base register with trap type |
| pc | output | 32 | Fetch address |
| npc | output | 32 | Next fetch address |
| redirect | output | 1 | Fetch redirected to a trap vector |
| err_mode | output | 1 | Sticky error halt |
| fetch_en | output | 1 | Instruction fetch allowed |
| sv_valid | output | 1 | Saved pair valid |
| sv_ready | input | 1 | Register file takes the saved pair |
| sv_pc | output | 32 | Saved pc, for local 1 |
| sv_npc | output | 32 | Saved npc, for local 2 |
| sv_win | output | 3 | Window that receives the saved pair |

## Verification
The mask filter is tried with lines below, at and above the level, with several lines raised together, and with level 15 under a full mask. These cases tell a strict comparison from an inclusive one and show that level 15 bypasses the mask. The saved pair is tested with an interrupt arriving alone and with an interrupt arriving together with a retirement, which shows whether the following instruction pair is chosen. A synchronous trap is raised alongside an interrupt, which separates the arbitration order. A stall on the save stream with a new request waiting shows that entry is blocked and the pair stays stable. The error path is tested by retiring and writing state while halted, which shows that nothing moves until the reset trap. The reset trap is checked for keeping the mask, window and trap base.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN        = 32;
  localparam int TT_W        = 8;
  localparam int TT_LSB      = 4;
  localparam logic [TT_W-1:0] TT_IRQ_BASE = 8'h10;

  typedef enum logic [2:0] {
    ACT_RUN,
    ACT_RESET,
    ACT_HALT,
    ACT_ERROR,
    ACT_SYNC,
    ACT_IRQ
  } act_e;

  function automatic logic [XLEN-1:0] vec_addr(
    input logic [XLEN-TT_W-TT_LSB-1:0] base,
    input logic [TT_W-1:0]             tt
  );
    return {base, tt, {TT_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/trap_irq_arb.sv
module trap_irq_arb #(
  parameter int NLVL = 16,
  localparam int LW = $clog2(NLVL)
) (
  input  logic [NLVL-1:1] req,
  input  logic [LW-1:0]   pil,
  output logic            hit,
  output logic [LW-1:0]   lvl
);
  logic [NLVL-1:1] elig;

  for (genvar g = 1; g < NLVL; g++) begin : g_lvl
    if (g == NLVL - 1) begin : g_top
      assign elig[g] = req[g];
    end else begin : g_masked
      assign elig[g] = req[g] && (LW'(g) > pil);
    end
  end

  always_comb begin
    hit = 1'b0;
    lvl = '0;
    for (int i = 1; i < NLVL; i++) begin
      if (elig[i]) begin
        hit = 1'b1;
        lvl = LW'(i);
      end
    end
  end
endmodule

// File: rtl/trap_decide.sv
module trap_decide
  import trap_pkg::*;
(
  input  logic rst_trap,
  input  logic err,
  input  logic et,
  input  logic strap_valid,
  input  logic irq_hit,
  input  logic slot_free,
  output act_e act,
  output logic strap_ready
);
  always_comb begin
    strap_ready = !rst_trap && !err && (!et || slot_free);
    if (rst_trap)                       act = ACT_RESET;
    else if (err)                       act = ACT_HALT;
    else if (strap_valid && !et)        act = ACT_ERROR;
    else if (strap_valid)               act = slot_free ? ACT_SYNC : ACT_RUN;
    else if (et && irq_hit && slot_free) act = ACT_IRQ;
    else                                act = ACT_RUN;
  end
endmodule

// File: rtl/trap_save_port.sv
module trap_save_port #(
  parameter int AW = 32,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [AW-1:0] in_pc,
  input  logic [AW-1:0] in_npc,
  input  logic [CW-1:0] in_win,
  input  logic          ready,
  output logic          valid,
  output logic          free,
  output logic [AW-1:0] out_pc,
  output logic [AW-1:0] out_npc,
  output logic [CW-1:0] out_win
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      out_pc  <= '0;
      out_npc <= '0;
      out_win <= '0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (load) begin
      valid   <= 1'b1;
      out_pc  <= in_pc;
      out_npc <= in_npc;
      out_win <= in_win;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_entry_ctl.sv
module trap_entry_ctl
  import trap_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int NLVL   = 16,
  parameter logic [31:0] RST_PC = 32'h0,
  localparam int CW    = $clog2(NWIN),
  localparam int LW    = $clog2(NLVL),
  localparam int TBA_W = XLEN - TT_W - TT_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_trap,
  input  logic [NLVL-1:1]  irq_req,
  input  logic             strap_valid,
  output logic             strap_ready,
  input  logic [TT_W-1:0]  strap_tt,
  input  logic             retire,
  input  logic [XLEN-1:0]  retire_npc,
  input  logic             psr_we,
  input  logic             psr_et,
  input  logic             psr_s,
  input  logic             psr_ps,
  input  logic [LW-1:0]    psr_pil,
  input  logic [CW-1:0]    psr_cwp,
  input  logic             tbr_we,
  input  logic [TBA_W-1:0] tbr_base,
  output logic             et,
  output logic             s,
  output logic             ps,
  output logic [LW-1:0]    pil,
  output logic [CW-1:0]    cwp,
  output logic [XLEN-1:0]  tbr,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  npc,
  output logic             redirect,
  output logic             err_mode,
  output logic             fetch_en,
  output logic             sv_valid,
  input  logic             sv_ready,
  output logic [XLEN-1:0]  sv_pc,
  output logic [XLEN-1:0]  sv_npc,
  output logic [CW-1:0]    sv_win
);
  logic [TBA_W-1:0] tba_q;
  logic [TT_W-1:0]  tt_q;
  logic             irq_hit;
  logic [LW-1:0]    irq_lvl;
  logic             slot_free;
  act_e             act;
  logic             entering;
  logic [TT_W-1:0]  ent_tt;
  logic [XLEN-1:0]  ent_vec;
  logic [XLEN-1:0]  keep_pc, keep_npc;
  logic [CW-1:0]    cwp_dec;

  trap_irq_arb #(.NLVL(NLVL)) u_arb (
    .req (irq_req),
    .pil (pil),
    .hit (irq_hit),
    .lvl (irq_lvl)
  );

  trap_decide u_dec (
    .rst_trap    (rst_trap),
    .err         (err_mode),
    .et          (et),
    .strap_valid (strap_valid),
    .irq_hit     (irq_hit),
    .slot_free   (slot_free),
    .act         (act),
    .strap_ready (strap_ready)
  );

  assign entering = (act == ACT_SYNC) || (act == ACT_IRQ);
  assign ent_tt   = (act == ACT_SYNC) ? strap_tt : TT_IRQ_BASE + TT_W'(irq_lvl);
  assign ent_vec  = vec_addr(tba_q, ent_tt);
  assign cwp_dec  = (cwp == '0) ? CW'(NWIN - 1) : cwp - CW'(1);

  always_comb begin
    if (act == ACT_IRQ && retire) begin
      keep_pc  = npc;
      keep_npc = retire_npc;
    end else begin
      keep_pc  = pc;
      keep_npc = npc;
    end
  end

  trap_save_port #(.AW(XLEN), .CW(CW)) u_save (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (act == ACT_RESET),
    .load    (entering),
    .in_pc   (keep_pc),
    .in_npc  (keep_npc),
    .in_win  (cwp_dec),
    .ready   (sv_ready),
    .valid   (sv_valid),
    .free    (slot_free),
    .out_pc  (sv_pc),
    .out_npc (sv_npc),
    .out_win (sv_win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      et       <= 1'b0;
      s        <= 1'b1;
      ps       <= 1'b0;
      pil      <= '0;
      cwp      <= '0;
      tba_q    <= '0;
      tt_q     <= '0;
      pc       <= RST_PC;
      npc      <= RST_PC + 32'd4;
      err_mode <= 1'b0;
      redirect <= 1'b0;
    end else begin
      redirect <= entering;
      case (act)
        ACT_RESET: begin
          et       <= 1'b0;
          s        <= 1'b1;
          pc       <= RST_PC;
          npc      <= RST_PC + 32'd4;
          err_mode <= 1'b0;
        end
        ACT_HALT: ;
        ACT_ERROR: err_mode <= 1'b1;
        ACT_SYNC, ACT_IRQ: begin
          et   <= 1'b0;
          ps   <= s;
          s    <= 1'b1;
          cwp  <= cwp_dec;
          tt_q <= ent_tt;
          pc   <= ent_vec;
          npc  <= ent_vec + 32'd4;
        end
        default: begin
          if (psr_we) begin
            et  <= psr_et;
            s   <= psr_s;
            ps  <= psr_ps;
            pil <= psr_pil;
            cwp <= psr_cwp;
          end
          if (tbr_we) tba_q <= tbr_base;
          if (retire) begin
            pc  <= npc;
            npc <= retire_npc;
          end
        end
      endcase
    end
  end

  assign tbr      = vec_addr(tba_q, tt_q);
  assign fetch_en = !err_mode;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_trap,
  input logic          strap_valid,
  input logic          et,
  input logic          s,
  input logic [3:0]    pil,
  input logic [CW-1:0] cwp,
  input logic [31:0]   pc,
  input logic [31:0]   npc,
  input logic [31:0]   tbr,
  input logic          redirect,
  input logic          err_mode,
  input logic          fetch_en,
  input logic          sv_valid,
  input logic          sv_ready,
  input logic [31:0]   sv_pc,
  input logic [31:0]   sv_npc
);
  AST_ENTRY_PSR: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!et && s && pil == $past(pil) &&
                  cwp == (($past(cwp) == '0) ? CW'(NWIN - 1) : $past(cwp) - CW'(1)))); // R5

  AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (pc == tbr && npc == pc + 32'd4 && sv_valid)); // R6

  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!et && !strap_valid && !rst_trap) |=> !redirect); // R4

  AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_valid && !sv_ready && !rst_trap) |=> (sv_valid && $stable(sv_pc) && $stable(sv_npc) && !redirect)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mode && !rst_trap) |=> (err_mode && $stable(pc) && $stable(npc))); // R10

  AST_ERR_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |-> !fetch_en); // R10

  AST_RESET_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_trap |=> (pc == 32'd0 && npc == 32'd4 && s && !et && !err_mode && !sv_valid)); // R2
endmodule

bind trap_entry_ctl trap_entry_chk #(.NWIN(NWIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_trap    (rst_trap),
  .strap_valid (strap_valid),
  .et          (et),
  .s           (s),
  .pil         (pil),
  .cwp         (cwp),
  .pc          (pc),
  .npc         (npc),
  .tbr         (tbr),
  .redirect    (redirect),
  .err_mode    (err_mode),
  .fetch_en    (fetch_en),
  .sv_valid    (sv_valid),
  .sv_ready    (sv_ready),
  .sv_pc       (sv_pc),
  .sv_npc      (sv_npc)
);

// File: tb/tb_trap_entry_ctl.sv
`timescale 1ns/1ps
module tb_trap_entry_ctl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, rst_trap, strap_valid, retire, psr_we, psr_et, psr_s, psr_ps, tbr_we, sv_ready;
  logic [15:1] irq_req;
  logic [7:0]  strap_tt;
  logic [31:0] retire_npc;
  logic [3:0]  psr_pil;
  logic [2:0]  psr_cwp;
  logic [19:0] tbr_base;
  logic        strap_ready, et, s, ps, redirect, err_mode, fetch_en, sv_valid;
  logic [3:0]  pil;
  logic [2:0]  cwp, sv_win;
  logic [31:0] tbr, pc, npc, sv_pc, sv_npc;

  trap_entry_ctl dut (
    .clk(clk), .rst_n(rst_n), .rst_trap(rst_trap), .irq_req(irq_req),
    .strap_valid(strap_valid), .strap_ready(strap_ready), .strap_tt(strap_tt),
    .retire(retire), .retire_npc(retire_npc), .psr_we(psr_we), .psr_et(psr_et),
    .psr_s(psr_s), .psr_ps(psr_ps), .psr_pil(psr_pil), .psr_cwp(psr_cwp),
    .tbr_we(tbr_we), .tbr_base(tbr_base), .et(et), .s(s), .ps(ps), .pil(pil),
    .cwp(cwp), .tbr(tbr), .pc(pc), .npc(npc), .redirect(redirect),
    .err_mode(err_mode), .fetch_en(fetch_en), .sv_valid(sv_valid),
    .sv_ready(sv_ready), .sv_pc(sv_pc), .sv_npc(sv_npc), .sv_win(sv_win)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference model
  bit m_et, m_s, m_ps, m_err, m_red, m_svv;
  int m_pil, m_cwp, m_tt;
  logic [31:0] m_tba, m_pc, m_npc, m_svpc, m_svnpc;
  int m_svwin;
  string m_tag = "R1";

  function automatic logic [31:0] vec(logic [31:0] base, int tt);
    return (base << 12) | (32'(tt) << 4);
  endfunction

  task automatic m_enter(int tt, logic [31:0] spc, logic [31:0] snpc);
    m_ps = m_s; m_s = 1; m_et = 0;
    m_cwp = (m_cwp + 7) % 8;
    m_tt = tt;
    m_pc = vec(m_tba, tt); m_npc = m_pc + 4;
    m_svv = 1; m_svpc = spc; m_svnpc = snpc; m_svwin = m_cwp;
    m_red = 1;
  endtask

  always @(posedge clk) begin
    bit free;
    int lvl;
    m_red = 0;
    if (!rst_n) begin
      m_et = 0; m_s = 1; m_ps = 0; m_pil = 0; m_cwp = 0; m_tba = 0; m_tt = 0;
      m_pc = 0; m_npc = 4; m_err = 0; m_svv = 0; m_svpc = 0; m_svnpc = 0; m_svwin = 0;
      m_tag = "R1";
    end else if (rst_trap) begin
      m_et = 0; m_s = 1; m_pc = 0; m_npc = 4; m_err = 0; m_svv = 0; m_tag = "R2";
    end else if (m_err) begin
      m_tag = "R10";
    end else begin
      free = !m_svv || sv_ready;
      lvl = 0;
      for (int i = 1; i <= 15; i++)
        if (irq_req[i] && (i > m_pil || i == 15)) lvl = i;
      if (m_svv && sv_ready) m_svv = 0;
      if (strap_valid && !m_et) begin
        m_err = 1; m_tag = "R10";
      end else if (strap_valid && free) begin
        m_enter(int'(strap_tt), m_pc, m_npc); m_tag = "R9";
      end else if (!strap_valid && m_et && lvl != 0 && free) begin
        if (retire) m_enter(16 + lvl, m_npc, retire_npc);
        else        m_enter(16 + lvl, m_pc, m_npc);
        m_tag = "R7";
      end else begin
        m_tag = "R11";
        if (psr_we) begin
          m_et = psr_et; m_s = psr_s; m_ps = psr_ps; m_pil = psr_pil; m_cwp = psr_cwp;
        end
        if (tbr_we) m_tba = 32'(tbr_base);
        if (retire) begin m_pc = m_npc; m_npc = retire_npc; end
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    logic [199:0] a, e;
    bit m_sr;
    @(posedge clk); #2;
    m_sr = !m_err && !rst_trap && (!m_et || !m_svv || sv_ready);
    a = {et, s, ps, pil, cwp, tbr, pc, npc, redirect, err_mode, fetch_en, sv_valid, strap_ready,
         sv_valid ? {sv_pc, sv_npc, sv_win} : 67'd0};
    e = {m_et, m_s, m_ps, 4'(m_pil), 3'(m_cwp), vec(m_tba, m_tt), m_pc, m_npc, m_red, m_err, !m_err,
         m_svv, m_sr, m_svv ? {m_svpc, m_svnpc, 3'(m_svwin)} : 67'd0};
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s model actual=%h expected=%h", m_tag, a, e);
    end
  endtask

  task automatic idle();
    rst_trap = 0; strap_valid = 0; retire = 0; psr_we = 0; tbr_we = 0; irq_req = '0;
  endtask

  task automatic wpsr(bit e_, bit s_, int pl, int cw);
    psr_we = 1; psr_et = e_; psr_s = s_; psr_ps = 0; psr_pil = 4'(pl); psr_cwp = 3'(cw);
    cyc(); psr_we = 0;
  endtask

  initial begin
    rst_n = 0; idle(); sv_ready = 1; strap_tt = 0; retire_npc = 0;
    psr_et = 0; psr_s = 0; psr_ps = 0; psr_pil = 0; psr_cwp = 0; tbr_base = 0;
    cyc(); cyc();
    // R1 reset state
    chk("R1", {32'(pc), 32'(npc)}, {32'd0, 32'd4});
    chk("R1", {60'd0, et, s, err_mode, sv_valid}, {60'd0, 4'b0100});
    rst_n = 1;
    tbr_we = 1; tbr_base = 20'h12345; cyc(); tbr_we = 0;
    wpsr(1, 0, 5, 3);
    retire = 1; retire_npc = 32'h8; cyc(); retire = 0;
    chk("R11", {pc, npc}, {32'h4, 32'h8});
    // R3: levels at or below mask ignored
    irq_req[3] = 1; irq_req[5] = 1; cyc(); cyc();
    chk("R3", {32'd0, pc}, {32'd0, 32'h4});
    // R3 highest eligible wins, R6 vector, R7 saved pair
    irq_req = '0; irq_req[7] = 1; irq_req[6] = 1; sv_ready = 0; cyc(); irq_req = '0;
    chk("R6", {tbr, pc}, {32'h12345170, 32'h12345170});
    chk("R7", {sv_pc, sv_npc}, {32'h4, 32'h8});
    chk("R5", {56'd0, et, s, ps, pil, cwp[0]}, {56'd0, 1'b0, 1'b1, 1'b0, 4'd5, 1'b0});
    // R8 hold under back-pressure
    cyc(); cyc();
    chk("R8", {31'd0, sv_valid, sv_pc}, {31'd0, 1'b1, 32'h4});
    sv_ready = 1; cyc();
    chk("R8", {63'd0, sv_valid}, 64'd0);
    // R4 interrupts ignored when traps disabled
    irq_req[15] = 1; irq_req[9] = 1; cyc(); cyc(); irq_req = '0;
    chk("R4", {32'd0, pc}, {32'd0, 32'h12345170});
    // R3 level 15 under full mask, R5 window wrap
    wpsr(1, 0, 15, 0);
    irq_req[14] = 1; cyc(); irq_req = '0;
    chk("R3", {32'd0, pc}, {32'd0, 32'h12345170});
    irq_req[15] = 1; cyc(); irq_req = '0;
    chk("R5", {61'd0, cwp}, {61'd0, 3'd7});
    chk("R3", {32'd0, pc}, {32'd0, 32'h123451F0});
    // R9 sync trap beats interrupt
    wpsr(1, 1, 0, 4);
    strap_valid = 1; strap_tt = 8'h05; irq_req[2] = 1; cyc(); strap_valid = 0; irq_req = '0;
    chk("R9", {pc, sv_pc}, {32'h12345050, 32'h123451F0});
    chk("R5", {62'd0, ps, s}, {62'd0, 2'b11});
    // R7 interrupt with retire in the same cycle
    wpsr(1, 0, 0, 4);
    irq_req[9] = 1; retire = 1; retire_npc = 32'h2000; cyc(); irq_req = '0; retire = 0;
    chk("R7", {sv_pc, sv_npc}, {32'h12345054, 32'h2000});
    chk("R6", {32'd0, pc}, {32'd0, 32'h12345190});
    // R10 sync trap with traps disabled
    strap_valid = 1; strap_tt = 8'h02; cyc(); strap_valid = 0;
    chk("R10", {62'd0, err_mode, fetch_en}, {62'd0, 2'b10});
    retire = 1; retire_npc = 32'h40; wpsr(1, 0, 9, 1); retire = 0; cyc();
    chk("R10", {pc, 28'd0, pil}, {32'h12345190, 28'd0, 4'd0});
    // R2 reset trap keeps mask, window, trap base
    rst_trap = 1; cyc(); rst_trap = 0;
    chk("R2", {pc, npc}, {32'h0, 32'h4});
    chk("R2", {tbr, 21'd0, err_mode, pil, cwp, et, s, fetch_en}, {32'h12345190, 21'd0, 1'b0, 4'd0, 3'd3, 1'b0, 1'b1, 1'b1});
    // R8 new trap waits for a stalled save slot
    wpsr(1, 0, 0, 3);
    sv_ready = 0; irq_req[4] = 1; cyc(); irq_req = '0;
    wpsr(1, 0, 0, 2);
    irq_req[8] = 1; cyc(); cyc();
    chk("R8", {31'd0, strap_ready, pc}, {31'd0, 1'b0, 32'h12345140});
    sv_ready = 1; cyc(); irq_req = '0;
    chk("R8", {32'd0, pc}, {32'd0, 32'h12345180});
    cyc(); cyc();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule